// File: doc/BRIEF.md
# Serial EEPROM Slave Transaction Controller

This block is the transaction engine of a 128-byte serial memory that answers as a slave on a two-wire I2C bus. An input stage outside the block detects START and STOP conditions and the SCL edges and delivers each as a single-cycle pulse. It also delivers the sampled SDA level. The controller checks the control byte and loads the word address. It then runs byte and multi-byte writes, current-address reads, random reads and sequential reads. It pulls SDA low through an open-drain enable to acknowledge bytes and to send read data.

The memory array sits inside the block and is read synchronously. Written bytes are not stored here directly. Each received data byte is handed out on a one-cycle strobe with its address. A commit pulse follows the STOP that closes a write. A separate commit block buffers the bytes, runs the timed programming cycle and writes the array back through a plain write port. While that block reports busy, the controller stays silent, so a master can poll for completion.

Top module: `e2_slave_ctrl`

## Requirements
- R1: After reset, `sda_oe` is low, no data strobe or commit pulse is raised, the address pointer is 0 and every array byte reads 0x00.
- R2: The controller acknowledges a control byte only when bits 7:4 are 1010, whatever bits 3:1 hold. Bit 0 selects read (1) or write (0). With any other code it acknowledges nothing and drives nothing until the next START.
- R3: An acknowledge raises `sda_oe` in the first clock after the SCL fall that follows the eighth data rise. It holds `sda_oe` through the ninth rise and drops it in the first clock after the following fall. `sda_oe` changes only after an SCL fall, a START or a STOP.
- R4: In a write, the byte after the control byte is the word address. It is acknowledged, and its bits 6:0 load the pointer; bit 7 is ignored.
- R5: Each later write byte is acknowledged. It is presented on `dat_valid` for exactly one clock, with `dat_addr` equal to the pointer, and the pointer then increases by one.
- R6: `commit` pulses for one clock, one clock after a STOP, only when the write being closed received at least one data byte.
- R7: A repeated START after the word address ends the write with no commit, and the pointer keeps the loaded address.
- R8: A read sends the byte at the pointer, MSB first, with `sda_oe` high for each 0 bit, and advances the pointer by one. A read with no address phase continues from where the last access left the pointer.
- R9: In a read, a master ACK (SDA low on the ninth rise) starts the next byte, and the pointer wraps from 0x7F to 0x00. A master NACK releases SDA and ends output until the next START.
- R10: While `wr_busy` is high, the controller does not acknowledge even a valid control byte.
- R11: A START at any bit position abandons the transaction in progress, releases SDA and begins a new control byte with no commit.
- R12: A `mem_we` pulse writes `mem_wdata` into the array at `mem_waddr`, and later reads return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_evt | input | 1 | One-cycle pulse: START or repeated START detected |
| stop_evt | input | 1 | One-cycle pulse: STOP detected |
| scl_rise | input | 1 | One-cycle pulse: SCL rising edge; SDA is sampled here |
| scl_fall | input | 1 | One-cycle pulse: SCL falling edge |
| sda_in | input | 1 | Sampled level of the SDA line |
| wr_busy | input | 1 | Commit block is programming the array |
| mem_we | input | 1 | Array write strobe from the commit block |
| mem_waddr | input | 7 | Array write address |
| mem_wdata | input | 8 | Array write data |
| sda_oe | output | 1 | Pull SDA low when high |
| dat_valid | output | 1 | One-cycle strobe for a received write byte |
| dat_addr | output | 7 | Address for the strobed byte |
| dat_byte | output | 8 | Strobed write byte |
| commit | output | 1 | One-cycle request to program the collected bytes |

## Verification
Every output of this block moves on the first clock edge that samples the event pulse causing it. Acknowledge and read bits follow an SCL fall, data strobes follow the eighth SCL rise of a write byte, and commit follows STOP. The bench drives one event pulse per edge. Right after that edge it updates its behavioural expectation for `sda_oe`, the data strobe and commit, and it compares all of them on every falling clock edge, so each result is checked exactly in the cycle it becomes due and in the cycle after it must be gone. At each ninth rise the bench also reads the acknowledge level from the wired SDA line, and it reassembles every read byte from the line at the SCL rises.

// File: rtl/e2_pkg.sv
package e2_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_WADDR,
    ST_WDATA,
    ST_READ
  } e2_state_t;

  // Control-byte device code check: only the upper nibble matters.
  function automatic logic code_match(input logic [BYTE_W-1:0] b,
                                      input logic [3:0] code);
    return b[BYTE_W-1 -: 4] == code;
  endfunction
endpackage

// File: rtl/e2_bit_frame.sv
// Counts SCL rises inside a 9-bit frame and shifts in SDA.
module e2_bit_frame
  import e2_pkg::*;
#(
  parameter int BITS = BYTE_W,
  parameter int CW   = $clog2(BITS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_evt,
  input  logic            stop_evt,
  input  logic            scl_rise,
  input  logic            sda_in,
  output logic [CW-1:0]   bcnt,
  output logic            byte_done,
  output logic            ack_rise,
  output logic [BITS-1:0] rx_byte
);
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);
  localparam logic [CW-1:0] ACKB = CW'(BITS);

  logic [BITS-1:0] shreg;

  assign byte_done = scl_rise && (bcnt == LAST);
  assign ack_rise  = scl_rise && (bcnt == ACKB);
  assign rx_byte   = {shreg[BITS-2:0], sda_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt  <= '0;
      shreg <= '0;
    end else if (start_evt || stop_evt) begin
      bcnt <= '0;
    end else if (scl_rise) begin
      if (bcnt == ACKB) begin
        bcnt <= '0;
      end else begin
        bcnt  <= bcnt + 1'b1;
        shreg <= rx_byte;
      end
    end
  end
endmodule

// File: rtl/e2_mem_array.sv
// Register array with one write port and a registered read port.
module e2_mem_array #(
  parameter int AW = 7,
  parameter int DW = 8,
  parameter int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
      rdata <= '0;
    end else begin
      if (we) cells[waddr] <= wdata;
      rdata <= cells[raddr];
    end
  end
endmodule

// File: rtl/e2_slave_ctrl.sv
module e2_slave_ctrl
  import e2_pkg::*;
#(
  parameter int          AW        = 7,
  parameter logic [3:0]  CTRL_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_in,
  input  logic              wr_busy,
  input  logic              mem_we,
  input  logic [AW-1:0]     mem_waddr,
  input  logic [BYTE_W-1:0] mem_wdata,
  output logic              sda_oe,
  output logic              dat_valid,
  output logic [AW-1:0]     dat_addr,
  output logic [BYTE_W-1:0] dat_byte,
  output logic              commit
);
  localparam int CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] ACK_SLOT = CW'(BYTE_W);

  // Pointer advance; wraps at the top of the array.
  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
    return p + 1'b1;
  endfunction

  e2_state_t         state;
  logic [CW-1:0]     bcnt;
  logic              byte_done, ack_rise;
  logic [BYTE_W-1:0] rx_byte, rdata, txb;
  logic [AW-1:0]     ptr;
  logic              ack_pend, rd_go, have_data;

  // Named events for the checker.
  logic ctrl_hit, in_read, mst_nack;
  assign ctrl_hit = (state == ST_CTRL) && code_match(rx_byte, CTRL_CODE) && !wr_busy;
  assign in_read  = (state == ST_READ);
  assign mst_nack = ack_rise && in_read && !ack_pend && sda_in;

  e2_bit_frame #(.BITS(BYTE_W), .CW(CW)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .scl_rise  (scl_rise),
    .sda_in    (sda_in),
    .bcnt      (bcnt),
    .byte_done (byte_done),
    .ack_rise  (ack_rise),
    .rx_byte   (rx_byte)
  );

  e2_mem_array #(.AW(AW), .DW(BYTE_W)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (ptr),
    .rdata (rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ptr       <= '0;
      txb       <= '0;
      ack_pend  <= 1'b0;
      rd_go     <= 1'b0;
      have_data <= 1'b0;
      sda_oe    <= 1'b0;
      dat_valid <= 1'b0;
      dat_addr  <= '0;
      dat_byte  <= '0;
      commit    <= 1'b0;
    end else begin
      dat_valid <= 1'b0;
      commit    <= 1'b0;
      if (start_evt) begin
        state     <= ST_CTRL;
        ack_pend  <= 1'b0;
        rd_go     <= 1'b0;
        have_data <= 1'b0;
        sda_oe    <= 1'b0;
      end else if (stop_evt) begin
        commit    <= (state == ST_WDATA) && have_data;
        state     <= ST_IDLE;
        ack_pend  <= 1'b0;
        rd_go     <= 1'b0;
        have_data <= 1'b0;
        sda_oe    <= 1'b0;
      end else begin
        if (byte_done) begin
          unique case (state)
            ST_CTRL: begin
              ack_pend <= ctrl_hit;
              if (!ctrl_hit)      state <= ST_IDLE;
              else if (rx_byte[0]) state <= ST_READ;
              else                state <= ST_WADDR;
            end
            ST_WADDR: begin
              ptr      <= rx_byte[AW-1:0];
              ack_pend <= 1'b1;
              state    <= ST_WDATA;
            end
            ST_WDATA: begin
              ack_pend  <= 1'b1;
              dat_valid <= 1'b1;
              dat_addr  <= ptr;
              dat_byte  <= rx_byte;
              ptr       <= ptr_step(ptr);
              have_data <= 1'b1;
            end
            default: ack_pend <= 1'b0;
          endcase
        end
        if (ack_rise && in_read) begin
          rd_go <= ack_pend || !sda_in;
          if (mst_nack) state <= ST_IDLE;
        end
        if (scl_fall) begin
          if (bcnt == ACK_SLOT) begin
            sda_oe <= ack_pend;
          end else if (bcnt == '0) begin
            ack_pend <= 1'b0;
            if (in_read && rd_go) begin
              txb    <= {rdata[BYTE_W-2:0], 1'b0};
              sda_oe <= ~rdata[BYTE_W-1];
              ptr    <= ptr_step(ptr);
              rd_go  <= 1'b0;
            end else begin
              sda_oe <= 1'b0;
            end
          end else if (in_read) begin
            sda_oe <= ~txb[BYTE_W-1];
            txb    <= {txb[BYTE_W-2:0], 1'b0};
          end else begin
            sda_oe <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/e2_slave_chk.sv
module e2_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic start_evt,
  input logic stop_evt,
  input logic scl_fall,
  input logic sda_oe,
  input logic dat_valid,
  input logic commit
);
  // R3: SDA is only ever pulled low after an SCL fall.
  a_r3_pull_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  // R3: a driven level holds while SCL is not falling and no bus event occurs.
  a_r3_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && !scl_fall && !start_evt && !stop_evt) |=> sda_oe);

  // R11: START releases SDA and raises no strobe.
  a_r11_start_abort: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (!sda_oe && !dat_valid && !commit));

  // R6: commit only directly after a STOP.
  a_r6_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(stop_evt));

  // R5: the data strobe lasts one clock.
  a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid |=> !dat_valid);

  // R9: STOP leaves SDA released.
  a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);
endmodule

bind e2_slave_ctrl e2_slave_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .scl_fall  (scl_fall),
  .sda_oe    (sda_oe),
  .dat_valid (dat_valid),
  .commit    (commit)
);

// File: tb/sim_e2_slave_ctrl.sv
module sim_e2_slave_ctrl;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, start_evt, stop_evt, scl_rise, scl_fall, sda_m, wr_busy, mem_we;
  logic [6:0] mem_waddr;
  logic [7:0] mem_wdata;
  logic sda_oe, dat_valid, commit;
  logic [6:0] dat_addr;
  logic [7:0] dat_byte;
  wire sda_in;
  assign sda_in = sda_m & ~sda_oe;

  e2_slave_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in), .wr_busy(wr_busy),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .sda_oe(sda_oe), .dat_valid(dat_valid), .dat_addr(dat_addr),
    .dat_byte(dat_byte), .commit(commit)
  );

  // Behavioural reference model
  logic [7:0] ref_mem [128];
  int ref_ptr;
  int q_addr[$];
  int q_data[$];
  logic exp_oe, exp_dv, exp_cm;
  logic [6:0] exp_da;
  logic [7:0] exp_db;
  string req = "R1";
  int nchk = 0, nerr = 0;
  bit live = 0, done = 0;

  task automatic chk(input bit ok, input string r, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  always @(negedge clk) if (live) begin
    chk(sda_oe === exp_oe, req, "sda_oe", int'(sda_oe), int'(exp_oe));
    chk(dat_valid === exp_dv, req, "dat_valid", int'(dat_valid), int'(exp_dv));
    if (exp_dv) begin
      chk(dat_addr === exp_da, req, "dat_addr", int'(dat_addr), int'(exp_da));
      chk(dat_byte === exp_db, req, "dat_byte", int'(dat_byte), int'(exp_db));
    end
    chk(commit === exp_cm, req, "commit", int'(commit), int'(exp_cm));
  end

  task automatic edge_evt(input bit r, input bit f, input bit s, input bit p);
    scl_rise = r; scl_fall = f; start_evt = s; stop_evt = p;
    @(posedge clk); #1;
    scl_rise = 0; scl_fall = 0; start_evt = 0; stop_evt = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    exp_dv = 0; exp_cm = 0; mem_we = 0;
  endtask

  task automatic bus_start();
    edge_evt(0, 0, 1, 0); exp_oe = 0; tick();
  endtask

  task automatic bus_stop(input bit cm);
    edge_evt(0, 0, 0, 1); exp_oe = 0; exp_cm = cm; tick();
  endtask

  // mode: 0 control, 1 word address, 2 write data, 3 ignored
  task automatic send_byte(input logic [7:0] b, input int mode,
                           input bit ack, input bit rd_follow);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i];
      edge_evt(1, 0, 0, 0);
      if (i == 0 && ack) begin
        if (mode == 1) ref_ptr = int'(b[6:0]);
        if (mode == 2) begin
          exp_dv = 1; exp_da = 7'(ref_ptr); exp_db = b;
          q_addr.push_back(ref_ptr); q_data.push_back(int'(b));
          ref_ptr = (ref_ptr + 1) % 128;
        end
      end
      tick();
      edge_evt(0, 1, 0, 0);
      if (i == 0) exp_oe = ack;
      tick();
    end
    sda_m = 1;
    edge_evt(1, 0, 0, 0);
    chk(sda_in == !ack, "R3", "ack level on ninth rise", int'(sda_in), int'(!ack));
    tick();
    edge_evt(0, 1, 0, 0);
    exp_oe = (ack && rd_follow) ? ~ref_mem[ref_ptr][7] : 1'b0;
    tick();
  endtask

  task automatic recv_byte(input bit m_ack);
    logic [7:0] e, got;
    e = ref_mem[ref_ptr];
    got = '0;
    ref_ptr = (ref_ptr + 1) % 128;
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      edge_evt(1, 0, 0, 0);
      got[i] = sda_in;
      tick();
      edge_evt(0, 1, 0, 0);
      exp_oe = (i > 0) ? ~e[i-1] : 1'b0;
      tick();
    end
    chk(got == e, "R8", "read byte", int'(got), int'(e));
    sda_m = ~m_ack;
    edge_evt(1, 0, 0, 0);
    tick();
    edge_evt(0, 1, 0, 0);
    exp_oe = m_ack ? ~ref_mem[ref_ptr][7] : 1'b0;
    tick();
    sda_m = 1;
  endtask

  // Emulates the commit block: R12 write port.
  task automatic flush(input bit stay_busy);
    wr_busy = 1;
    while (q_addr.size() > 0) begin
      int a, d;
      a = q_addr.pop_front(); d = q_data.pop_front();
      mem_we = 1; mem_waddr = 7'(a); mem_wdata = 8'(d);
      ref_mem[a] = 8'(d);
      tick();
    end
    if (!stay_busy) wr_busy = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    for (int i = 0; i < 128; i++) ref_mem[i] = 8'h00;
    ref_ptr = 0;
    exp_oe = 0; exp_dv = 0; exp_cm = 0; exp_da = '0; exp_db = '0;
    rst_n = 0; start_evt = 0; stop_evt = 0; scl_rise = 0; scl_fall = 0;
    sda_m = 1; wr_busy = 0; mem_we = 0; mem_waddr = '0; mem_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    @(negedge clk);
    chk(sda_oe == 0, "R1", "reset sda_oe", int'(sda_oe), 0);
    chk(dat_valid == 0, "R1", "reset dat_valid", int'(dat_valid), 0);
    chk(commit == 0, "R1", "reset commit", int'(commit), 0);
    @(posedge clk); #1;
    live = 1;

    // R1: pointer 0, array cleared: current read returns 0x00
    req = "R1";
    bus_start(); send_byte(8'hA1, 0, 1, 1); recv_byte(0); bus_stop(0);

    // R4/R5/R6: byte write with address MSB set, then commit
    req = "R5";
    bus_start(); send_byte(8'hA0, 0, 1, 0); send_byte(8'h85, 1, 1, 0);
    send_byte(8'h3C, 2, 1, 0);
    req = "R6"; bus_stop(1);
    req = "R12"; flush(1);

    // R10: busy, valid control byte gets no acknowledge
    req = "R10";
    bus_start(); send_byte(8'hA0, 0, 0, 0); bus_stop(0);
    wr_busy = 0;
    bus_start(); send_byte(8'hA0, 0, 1, 0);
    req = "R6"; bus_stop(0);

    // R5: multi-byte write crossing the top of the array, select bits 101
    req = "R5";
    bus_start(); send_byte(8'hAA, 0, 1, 0); send_byte(8'h7E, 1, 1, 0);
    send_byte(8'h11, 2, 1, 0); send_byte(8'h22, 2, 1, 0);
    send_byte(8'h33, 2, 1, 0); send_byte(8'h44, 2, 1, 0);
    bus_stop(1);
    req = "R12"; flush(0);

    // R7/R4: random read, address 0xFE -> 0x7E, repeated START, no commit
    req = "R7";
    bus_start(); send_byte(8'hA0, 0, 1, 0); send_byte(8'hFE, 1, 1, 0);
    bus_start();
    req = "R9";
    send_byte(8'hAF, 0, 1, 1);
    recv_byte(1); recv_byte(1); recv_byte(0);
    // after NACK nothing is driven or acknowledged
    send_byte(8'hFF, 3, 0, 0);
    bus_stop(0);

    // R8: current-address read continues at 0x01
    req = "R8";
    bus_start(); send_byte(8'hA1, 0, 1, 1); recv_byte(0); bus_stop(0);

    // R2: wrong device code, then silence for the next byte
    req = "R2";
    bus_start(); send_byte(8'h50, 0, 0, 0); send_byte(8'h00, 3, 0, 0);
    bus_stop(0);

    // R11: START two bits into a data byte abandons the write
    req = "R11";
    bus_start(); send_byte(8'hA0, 0, 1, 0); send_byte(8'h05, 1, 1, 0);
    for (int k = 0; k < 2; k++) begin
      sda_m = 1; edge_evt(1, 0, 0, 0); tick(); edge_evt(0, 1, 0, 0); tick();
    end
    bus_start();
    send_byte(8'hA3, 0, 1, 1); recv_byte(0); bus_stop(0);

    repeat (4) tick();
    live = 0;
    report();
  end
endmodule